// File: doc/BRIEF.md
# Cache Miss Type Classifier

This block observes a stream of byte-address accesses and classifies each one against a small cache model. The possible outcomes are a hit, a cold miss, a conflict miss or a capacity miss. It holds no data. It only keeps tags and bookkeeping, so a performance-analysis path can attribute every miss to its cause while a program runs.

Three models run side by side and all of them update on every access:

- The target cache is either direct-mapped or 2-way set-associative, chosen by a parameter.
- A fully associative shadow cache has the same number of block slots and replaces its least recently used block.
- A bitmap marks every block address that has ever been referenced.

The class comes from these three models:

- A block absent from the bitmap is a cold miss.
- A target hit is a hit.
- A target miss that the shadow would have served is a conflict miss.
- Any other miss is a capacity miss.

The result is registered and appears one cycle after the access. Three saturating counters tally the miss classes.

Top module: `miss_classifier`

## Requirements
- R1: The byte address splits into three fields. The low OFF_W bits are the byte offset within a block, the next bits select the set, and the upper bits form the tag. An access to any byte of a resident block is a hit. With the default 8-byte blocks, address 4 hits in the block that address 0 loaded.
- R2: The first reference to a block address that has never been referenced since reset reports class code 2'b01 (cold).
- R3: An access whose set holds a valid line with a matching tag reports class code 2'b00 (hit).
- R4: A target miss on a block that was referenced before reports class code 2'b10 (conflict) when the fully associative shadow holds that block.
- R5: A target miss on a block that was referenced before reports class code 2'b11 (capacity) when the shadow does not hold that block either.
- R6: The shadow holds LINES blocks. When it is full, a miss evicts its least recently used block. Every access makes the accessed block the most recently used.
- R7: With WAYS=2 the target has LINES/2 sets of two ways, and both tags of the selected set are compared. A miss fills an empty way first, otherwise the less recently used way of that set. With WAYS=1 each block has exactly one line.
- R8: res_valid rises in the cycle after each cycle with acc_valid high, and res_class holds that access's class. A cycle with acc_valid low produces no result and changes no state.
- R9: cnt_cold, cnt_conflict and cnt_capacity each add one per result of their class and stop at their all-ones value.
- R10: Synchronous reset clears both caches, the bitmap, the counters and res_valid. A block referenced before reset is cold again after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Byte address of the access |
| res_valid | output | 1 | Classification result valid |
| res_class | output | 2 | 00 hit, 01 cold, 10 conflict, 11 capacity |
| cnt_cold | output | CNT_W | Saturating count of cold misses |
| cnt_conflict | output | CNT_W | Saturating count of conflict misses |
| cnt_capacity | output | CNT_W | Saturating count of capacity misses |

## Verification
The hardest outcome to reach is a capacity miss. It needs a block that was referenced, then pushed out of the shadow by LINES other distinct blocks, and then missed by the target as well. The stimulus therefore touches five blocks that share set 0 and then returns to the first one. The conflict class is reached by two blocks that share a direct-mapped line and fit the shadow together. A second instance with WAYS=2 runs the same accesses, so the same addresses give hits or conflicts depending on associativity. Small counters saturate during a sweep of fresh blocks.

// File: rtl/mclass_pkg.sv
package mclass_pkg;
    typedef enum logic [1:0] {
        CLS_HIT      = 2'b00,
        CLS_COLD     = 2'b01,
        CLS_CONFLICT = 2'b10,
        CLS_CAPACITY = 2'b11
    } cls_e;
endpackage

// File: rtl/mclass_seen.sv
// Bitmap of every block address referenced since reset.
module mclass_seen #(
    parameter int BLK_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_en,
    input  logic [BLK_W-1:0] blk,
    output logic             seen
);
    localparam int NBLK = 1 << BLK_W;

    typedef struct packed {
        logic [NBLK-1:0] map;
    } seen_st_t;

    seen_st_t st_d, st_q;

    assign seen = st_q.map[blk];

    always_comb begin
        st_d = st_q;
        if (upd_en) begin
            st_d.map[blk] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/mclass_shadow.sv
// Fully associative tag store with LRU replacement using per-entry age ranks.
// Ages always form a permutation of 0..LINES-1; age LINES-1 is the victim.
module mclass_shadow #(
    parameter int BLK_W = 9,
    parameter int LINES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_en,
    input  logic [BLK_W-1:0] blk,
    output logic             hit
);
    localparam int AGE_W = (LINES > 1) ? $clog2(LINES) : 1;
    localparam logic [AGE_W-1:0] OLDEST = AGE_W'(LINES - 1);

    typedef struct packed {
        logic             vld;
        logic [BLK_W-1:0] tag;
        logic [AGE_W-1:0] age;
    } sh_ent_t;

    sh_ent_t [LINES-1:0] ent_d, ent_q;
    logic    [LINES-1:0] match;
    logic    [AGE_W-1:0] hit_age;
    logic    [AGE_W-1:0] ref_age;

    always_comb begin
        match   = '0;
        hit_age = '0;
        for (int i = 0; i < LINES; i++) begin
            if (ent_q[i].vld && ent_q[i].tag == blk) begin
                match[i] = 1'b1;
                hit_age  = ent_q[i].age;
            end
        end
    end

    assign hit     = |match;
    assign ref_age = hit ? hit_age : OLDEST;

    always_comb begin
        ent_d = ent_q;
        if (upd_en) begin
            for (int i = 0; i < LINES; i++) begin
                if (hit ? match[i] : (ent_q[i].age == OLDEST)) begin
                    ent_d[i].vld = 1'b1;
                    ent_d[i].tag = blk;
                    ent_d[i].age = '0;
                end else if (ent_q[i].age < ref_age) begin
                    ent_d[i].age = ent_q[i].age + AGE_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                ent_q[i].vld <= 1'b0;
                ent_q[i].tag <= '0;
                ent_q[i].age <= AGE_W'(i);
            end
        end else begin
            ent_q <= ent_d;
        end
    end
endmodule

// File: rtl/mclass_target.sv
// Target cache tag store: direct-mapped (WAYS=1) or 2-way with per-set LRU.
module mclass_target #(
    parameter int BLK_W = 9,
    parameter int LINES = 4,
    parameter int WAYS  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_en,
    input  logic [BLK_W-1:0] blk,
    output logic             hit
);
    localparam int SETS  = LINES / WAYS;
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int TAG_W = BLK_W - IDX_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
    } line_t;

    typedef struct packed {
        line_t [SETS-1:0][WAYS-1:0] line;
        logic  [SETS-1:0]           mru;
    } tgt_st_t;

    tgt_st_t st_d, st_q;

    logic [IDX_W-1:0] set_sel;
    logic [TAG_W-1:0] tag_in;
    logic [WAYS-1:0]  way_hit;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] vic_way;

    assign set_sel = blk[IDX_W-1:0];
    assign tag_in  = blk[BLK_W-1:IDX_W];

    always_comb begin
        way_hit = '0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (st_q.line[set_sel][w].vld && st_q.line[set_sel][w].tag == tag_in) begin
                way_hit[w] = 1'b1;
                hit_way    = WAY_W'(w);
            end
        end
    end

    assign hit = |way_hit;

    generate
        if (WAYS == 1) begin : g_direct
            assign vic_way = '0;
        end else begin : g_two_way
            always_comb begin
                if (!st_q.line[set_sel][0].vld)      vic_way = WAY_W'(0);
                else if (!st_q.line[set_sel][1].vld) vic_way = WAY_W'(1);
                else                                 vic_way = WAY_W'(~st_q.mru[set_sel]);
            end
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (upd_en) begin
            if (hit) begin
                st_d.mru[set_sel] = hit_way[0];
            end else begin
                st_d.line[set_sel][vic_way].vld = 1'b1;
                st_d.line[set_sel][vic_way].tag = tag_in;
                st_d.mru[set_sel]               = vic_way[0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/miss_classifier.sv
module miss_classifier
    import mclass_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int OFF_W  = 3,
    parameter int LINES  = 4,
    parameter int WAYS   = 1,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              res_valid,
    output logic [1:0]        res_class,
    output logic [CNT_W-1:0]  cnt_cold,
    output logic [CNT_W-1:0]  cnt_conflict,
    output logic [CNT_W-1:0]  cnt_capacity
);
    localparam int BLK_W = ADDR_W - OFF_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             res_valid;
        cls_e             res_class;
        logic [CNT_W-1:0] cold;
        logic [CNT_W-1:0] conflict;
        logic [CNT_W-1:0] capacity;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [BLK_W-1:0] blk;
    logic             seen;
    logic             tgt_hit;
    logic             sh_hit;
    cls_e             cls;

    assign blk = acc_addr[ADDR_W-1:OFF_W];

    mclass_seen #(.BLK_W(BLK_W)) u_seen (
        .clk(clk), .rst(rst), .upd_en(acc_valid), .blk(blk), .seen(seen)
    );

    mclass_shadow #(.BLK_W(BLK_W), .LINES(LINES)) u_shadow (
        .clk(clk), .rst(rst), .upd_en(acc_valid), .blk(blk), .hit(sh_hit)
    );

    mclass_target #(.BLK_W(BLK_W), .LINES(LINES), .WAYS(WAYS)) u_target (
        .clk(clk), .rst(rst), .upd_en(acc_valid), .blk(blk), .hit(tgt_hit)
    );

    always_comb begin
        if (tgt_hit)     cls = CLS_HIT;
        else if (!seen)  cls = CLS_COLD;
        else if (sh_hit) cls = CLS_CONFLICT;
        else             cls = CLS_CAPACITY;
    end

    always_comb begin
        st_d           = st_q;
        st_d.res_valid = acc_valid;
        if (acc_valid) begin
            st_d.res_class = cls;
            unique case (cls)
                CLS_COLD:     if (st_q.cold != CNT_MAX)     st_d.cold     = st_q.cold + CNT_W'(1);
                CLS_CONFLICT: if (st_q.conflict != CNT_MAX) st_d.conflict = st_q.conflict + CNT_W'(1);
                CLS_CAPACITY: if (st_q.capacity != CNT_MAX) st_d.capacity = st_q.capacity + CNT_W'(1);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{res_valid: 1'b0, res_class: CLS_HIT, cold: '0, conflict: '0, capacity: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid    = st_q.res_valid;
    assign res_class    = st_q.res_class;
    assign cnt_cold     = st_q.cold;
    assign cnt_conflict = st_q.conflict;
    assign cnt_capacity = st_q.capacity;
endmodule

// File: rtl/mclass_chk.sv
module mclass_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_valid,
    input logic             seen,
    input logic             tgt_hit,
    input logic             sh_hit,
    input logic             res_valid,
    input logic [1:0]       res_class,
    input logic [CNT_W-1:0] cnt_cold,
    input logic [CNT_W-1:0] cnt_conflict,
    input logic [CNT_W-1:0] cnt_capacity
);
    AST_RESULT_AFTER_ACCESS: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> res_valid); // R8
    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !res_valid); // R8
    AST_IDLE_KEEPS_COUNTS: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> $stable(cnt_cold) && $stable(cnt_conflict) && $stable(cnt_capacity)); // R8
    AST_TARGET_HIT_SEEN: assert property (@(posedge clk) disable iff (rst)
        tgt_hit |-> seen); // R2
    AST_SHADOW_HIT_SEEN: assert property (@(posedge clk) disable iff (rst)
        sh_hit |-> seen); // R6
    AST_COLD_CLASS: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !seen |=> res_class == 2'b01); // R2
    AST_CONFLICT_CLASS: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !tgt_hit && sh_hit |=> res_class == 2'b10); // R4
    AST_COLD_SATURATES: assert property (@(posedge clk) disable iff (rst)
        cnt_cold == '1 |=> cnt_cold == '1); // R9
    AST_CONFLICT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        cnt_conflict == '1 |=> cnt_conflict == '1); // R9
endmodule

bind miss_classifier mclass_chk #(.CNT_W(CNT_W)) i_mclass_chk (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .seen(seen), .tgt_hit(tgt_hit),
    .sh_hit(sh_hit), .res_valid(res_valid), .res_class(res_class),
    .cnt_cold(cnt_cold), .cnt_conflict(cnt_conflict), .cnt_capacity(cnt_capacity)
);

// File: tb/test_miss_classifier.sv
module test_miss_classifier;
    localparam int AW = 12;
    localparam int CW = 3;
    localparam logic [1:0] HT = 2'b00, CO = 2'b01, CF = 2'b10, CP = 2'b11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_valid = 1'b0;
    logic [AW-1:0] acc_addr = '0;

    logic          rv_dm, rv_sa;
    logic [1:0]    rc_dm, rc_sa;
    logic [CW-1:0] cc_dm, cf_dm, cp_dm, cc_sa, cf_sa, cp_sa;

    int tests = 0;
    int fails = 0;

    logic [1:0] q_dm[$];
    logic [1:0] q_sa[$];
    string      q_dm_r[$];
    string      q_sa_r[$];

    always #2 clk = ~clk;

    miss_classifier #(.ADDR_W(AW), .OFF_W(3), .LINES(4), .WAYS(1), .CNT_W(CW)) i_miss_classifier (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .res_valid(rv_dm), .res_class(rc_dm),
        .cnt_cold(cc_dm), .cnt_conflict(cf_dm), .cnt_capacity(cp_dm)
    );

    miss_classifier #(.ADDR_W(AW), .OFF_W(3), .LINES(4), .WAYS(2), .CNT_W(CW)) i_miss_classifier_2w (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .res_valid(rv_sa), .res_class(rc_sa),
        .cnt_cold(cc_sa), .cnt_conflict(cf_sa), .cnt_capacity(cp_sa)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // driver: present one access and queue the expected classes
    task automatic access(input int addr, input logic [1:0] e_dm, input logic [1:0] e_sa,
                          input string req);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_addr  = AW'(addr);
        q_dm.push_back(e_dm); q_dm_r.push_back({req, " dm"});
        q_sa.push_back(e_sa); q_sa_r.push_back({req, " 2w"});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            acc_valid = 1'b0;
            acc_addr  = AW'(i * 8);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        acc_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R10 res_valid after reset", int'(rv_dm) + int'(rv_sa), 0);
        check("R10 counters after reset",
              int'(cc_dm) + int'(cf_dm) + int'(cp_dm) + int'(cc_sa) + int'(cf_sa) + int'(cp_sa), 0);
    endtask

    // monitor: compare each result against the scoreboard queues
    always @(negedge clk) begin
        if (!rst) begin
            if (rv_dm) begin
                if (q_dm.size() == 0) begin
                    check("R8 unexpected dm result", 1, 0);
                end else begin
                    logic [1:0] e;
                    string r;
                    e = q_dm.pop_front();
                    r = q_dm_r.pop_front();
                    check(r, int'(rc_dm), int'(e));
                end
            end
            if (rv_sa) begin
                if (q_sa.size() == 0) begin
                    check("R8 unexpected 2w result", 1, 0);
                end else begin
                    logic [1:0] e;
                    string r;
                    e = q_sa.pop_front();
                    r = q_sa_r.pop_front();
                    check(r, int'(rc_sa), int'(e));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R10 res_valid after reset", int'(rv_dm) + int'(rv_sa), 0);
        check("R10 counters after reset", int'(cc_dm) + int'(cc_sa), 0);

        // Sequence A: blocks 0,0,1,3,7,1,3,2,0
        access(0,  CO, CO, "R2 first block 0");
        access(4,  HT, HT, "R1 same block other byte");
        access(8,  CO, CO, "R2 block 1");
        access(24, CO, CO, "R2 block 3");
        access(56, CO, CO, "R2 block 7");
        access(8,  HT, CF, "R7 block 1 evicted in 2-way set");
        access(24, CF, CF, "R4 block 3 refetch");
        access(16, CO, CO, "R2 block 2");
        access(0,  HT, HT, "R3 block 0 resident");
        idle(2);
        check("R9 dm cold count", int'(cc_dm), 5);
        check("R9 dm conflict count", int'(cf_dm), 1);
        check("R9 dm capacity count", int'(cp_dm), 0);
        check("R7 2w conflict count", int'(cf_sa), 2);

        // Sequence B: five blocks in set 0, then the first again
        do_reset();
        access(0,   CO, CO, "R10 block 0 cold again after reset");
        access(32,  CO, CO, "R2 block 4");
        access(64,  CO, CO, "R2 block 8");
        access(96,  CO, CO, "R2 block 12");
        access(128, CO, CO, "R6 block 16 evicts LRU in shadow");
        access(0,   CP, CP, "R5 block 0 capacity");
        idle(2);
        check("R5 dm capacity count", int'(cp_dm), 1);
        check("R5 2w capacity count", int'(cp_sa), 1);
        check("R9 2w cold count", int'(cc_sa), 5);

        // Sequence C: set-0 collisions, idle gap, then saturating sweep
        do_reset();
        access(0,  CO, CO, "R2 block 0");
        access(32, CO, CO, "R2 block 4");
        access(0,  CF, HT, "R4 R7 block 0 direct conflict vs 2-way hit");
        access(64, CO, CO, "R2 block 8");
        access(32, CF, CF, "R4 block 4");
        access(7,  CF, CF, "R1 R4 block 0 via byte 7");
        idle(5);
        check("R8 idle keeps dm cold", int'(cc_dm), 3);
        check("R8 idle keeps dm conflict", int'(cf_dm), 3);
        for (int k = 0; k < 10; k++) begin
            access(256 + 8 * k, CO, CO, "R2 sweep fresh block");
        end
        idle(2);
        check("R9 dm cold saturates", int'(cc_dm), 7);
        check("R9 2w cold saturates", int'(cc_sa), 7);
        check("R9 dm conflict count", int'(cf_dm), 3);
        check("R9 2w conflict count", int'(cf_sa), 2);
        check("R5 dm capacity stays zero", int'(cp_dm), 0);
        check("R8 all expected results seen", q_dm.size() + q_sa.size(), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule